// File: doc/BRIEF.md
# Serial-Bus Clock Register Slave

This block is the register front end of a battery-backed time-of-day clock. It sits on a two-wire serial bus as a slave with a fixed 7-bit address. It decodes the address and direction byte, takes a register pointer, and then writes or reads byte-wide registers. The bus pins are oversampled with a fast system clock. START and STOP are found as SDA edges while SCL is high. SDA is pulled low through an open-drain enable for acknowledge bits and for read data.

Ten locations are reachable.

- Locations 00h to 06h hold time and date. These bytes live in an external counting core. This block reads them from a 56-bit snapshot that is refreshed at defined events, so a multi-byte read sees a consistent time while the core keeps counting.
- Location 07h is the control register.
- Location 08h is the charger-configuration register.
- Location 09h is the flag register.

The block keeps locations 07h to 09h itself. Every accepted write to locations 00h to 09h is also presented to the core as a one-cycle strobe with address and data. While the power-fail input is high, the bus cannot reach the registers.

Top module: `rtc_bus_regs`

## Requirements
- R1: The slave acknowledges only the address byte whose upper seven bits are 1101000. Bit 0 of that byte set to 0 means write, and set to 1 means read. Any other address is not acknowledged, and nothing is written.
- R2: In a write, the first byte after the address loads the 4-bit pointer from its low nibble. Each later byte is written to the pointed location and appears on wr_en/wr_addr/wr_data, and then the pointer advances.
- R3: Advancing the pointer from 07h gives 00h, from 08h gives 09h, and from 09h gives 00h. Locations 00h to 06h advance by one.
- R4: The live time is copied into the snapshot on every START (including a repeated START), on every STOP, and whenever the pointer advances to 00h. Reads of locations 00h to 06h return byte k of the snapshot, which is live_time[8k+7:8k].
- R5: A written byte is committed at the SCL falling edge that ends its eighth bit, where the slave starts its acknowledge. It is not committed earlier.
- R6: A read begins at the stored pointer, even when no pointer was sent. Bytes are sent MSB first. Bytes keep coming while the master acknowledges. After a NACK, SDA is released.
- R7: The flag register reads {flag, 7'b0}. Its flag bit is 1 after reset. osc_stop sets the flag. Writing a byte with bit 7 equal to 0 clears the flag. Writing a byte with bit 7 equal to 1 leaves the flag unchanged.
- R8: The charger register resets to 00h and can be read back. chg_en is 1 only when:
  - bits 7:4 are 1010,
  - bits 3:2 are 01 or 10, and
  - bits 1:0 are not 00.
- R9: While pwr_fail is high, the address byte is not acknowledged, and no data byte is committed.
- R10: A repeated START abandons a partial byte, goes back to address reception and keeps the pointer.
- R11: The control register resets to 80h and reads back whatever was last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x SCL |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock as seen on the pin |
| sda_i | input | 1 | Bus data as seen on the pin |
| sda_oe | output | 1 | 1 pulls SDA low |
| pwr_fail | input | 1 | Blocks bus access while high |
| osc_stop | input | 1 | Sets the stop flag |
| live_time | input | 56 | Running time bytes, byte k at bits 8k+7:8k |
| wr_en | output | 1 | One-cycle strobe for a committed write |
| wr_addr | output | 4 | Location of the committed write |
| wr_data | output | 8 | Data of the committed write |
| ctrl_q | output | 8 | Control register |
| chg_q | output | 8 | Charger register |
| chg_en | output | 1 | Charger enabled decode |
| osf_q | output | 1 | Oscillator stop flag |

## Verification
Each bus edge passes two synchronizer flops and one edge register. The block reacts on the third rising clock edge after the pin changes. Acknowledge drive, read-data bits and the write strobe all settle within four system cycles of the SCL falling edge that causes them. The bench holds every SCL phase for eight cycles and samples SDA in the middle of the high phase, which is at least twelve cycles after the falling edge. Register outputs and the write log are checked one full phase after the byte ends. The commit check also looks one phase before the falling edge, to show that nothing arrives early.

// File: rtl/rtc_bus_regs.sv
module rtc_bus_regs #(
  parameter logic [6:0] DEV_ADDR   = 7'b1101000,
  parameter int         TIME_BYTES = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_i,
  input  logic                    sda_i,
  output logic                    sda_oe,
  input  logic                    pwr_fail,
  input  logic                    osc_stop,
  input  logic [8*TIME_BYTES-1:0] live_time,
  output logic                    wr_en,
  output logic [3:0]              wr_addr,
  output logic [7:0]              wr_data,
  output logic [7:0]              ctrl_q,
  output logic [7:0]              chg_q,
  output logic                    chg_en,
  output logic                    osf_q
);
  localparam int         TW     = 8*TIME_BYTES;
  localparam logic [3:0] CTRL_A = 4'(TIME_BYTES);
  localparam logic [3:0] CHG_A  = CTRL_A + 4'd1;
  localparam logic [3:0] FLAG_A = CTRL_A + 4'd2;

  typedef enum logic [2:0] {IDLE, ADDR, AACK, WRX, WACK, TX, MACK} st_t;

  logic [1:0]    scl_sy, sda_sy;
  logic          scl_p, sda_p;
  logic          scl_s, sda_s;
  logic          scl_rise, scl_fall, bus_start, bus_stop;
  st_t           st;
  logic [3:0]    cnt;
  logic [7:0]    sh, tx, rd_byte;
  logic          rw, got_ptr, mack;
  logic [3:0]    ptr, ptr_nx;
  logic [TW-1:0] snap;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= '1; sda_sy <= '1; scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_p  <= scl_sy[1];
      sda_p  <= sda_sy[1];
    end

  assign scl_s     = scl_sy[1];
  assign sda_s     = sda_sy[1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign bus_start = scl_s & scl_p & sda_p & ~sda_s;
  assign bus_stop  = scl_s & scl_p & ~sda_p & sda_s;

  function automatic logic [3:0] step(input logic [3:0] p);
    if (p == CTRL_A || p >= FLAG_A) return 4'd0;
    return p + 4'd1;
  endfunction

  assign ptr_nx = step(ptr);

  always_comb begin
    rd_byte = 8'h00;
    for (int i = 0; i < TIME_BYTES; i++)
      if (ptr == 4'(i)) rd_byte = snap[8*i +: 8];
    if (ptr == CTRL_A) rd_byte = ctrl_q;
    if (ptr == CHG_A)  rd_byte = chg_q;
    if (ptr == FLAG_A) rd_byte = {osf_q, 7'b0};
  end

  assign chg_en = (chg_q[7:4] == 4'b1010) && (chg_q[3:2] == 2'b01 || chg_q[3:2] == 2'b10)
                  && (chg_q[1:0] != 2'b00);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; sh <= '0; tx <= '0; rw <= 1'b0; got_ptr <= 1'b0; mack <= 1'b0;
      ptr <= '0; snap <= '0; sda_oe <= 1'b0; wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
      ctrl_q <= 8'h80; chg_q <= 8'h00; osf_q <= 1'b1;
    end else begin
      wr_en <= 1'b0;
      if (bus_start) begin
        st <= ADDR; cnt <= '0; sda_oe <= 1'b0; snap <= live_time;
      end else if (bus_stop) begin
        st <= IDLE; sda_oe <= 1'b0; snap <= live_time;
      end else begin
        if (scl_rise && (st == ADDR || st == WRX)) begin
          sh  <= {sh[6:0], sda_s};
          cnt <= cnt + 4'd1;
        end
        if (scl_rise && st == MACK) mack <= ~sda_s;
        if (scl_fall)
          case (st)
            ADDR:
              if (cnt == 4'd8) begin
                cnt <= '0;
                if (sh[7:1] == DEV_ADDR && !pwr_fail) begin
                  st <= AACK; rw <= sh[0]; sda_oe <= 1'b1;
                end else st <= IDLE;
              end
            AACK: begin
              got_ptr <= 1'b0;
              if (rw) begin
                st <= TX; tx <= rd_byte; sda_oe <= ~rd_byte[7]; cnt <= 4'd1;
              end else begin
                st <= WRX; sda_oe <= 1'b0; cnt <= '0;
              end
            end
            WRX:
              if (cnt == 4'd8) begin
                cnt <= '0;
                if (pwr_fail) st <= IDLE;
                else begin
                  st <= WACK; sda_oe <= 1'b1;
                  if (!got_ptr) begin
                    got_ptr <= 1'b1;
                    ptr     <= sh[3:0];
                  end else begin
                    if (ptr <= FLAG_A) begin
                      wr_en <= 1'b1; wr_addr <= ptr; wr_data <= sh;
                    end
                    if (ptr == CTRL_A) ctrl_q <= sh;
                    if (ptr == CHG_A)  chg_q  <= sh;
                    if (ptr == FLAG_A && !sh[7]) osf_q <= 1'b0;
                    ptr <= ptr_nx;
                    if (ptr_nx == 4'd0) snap <= live_time;
                  end
                end
              end
            WACK: begin
              st <= WRX; sda_oe <= 1'b0;
            end
            TX:
              if (cnt == 4'd8) begin
                st <= MACK; sda_oe <= 1'b0; cnt <= '0; ptr <= ptr_nx;
                if (ptr_nx == 4'd0) snap <= live_time;
              end else begin
                sda_oe <= ~tx[6];
                tx     <= {tx[6:0], 1'b0};
                cnt    <= cnt + 4'd1;
              end
            MACK:
              if (mack) begin
                st <= TX; tx <= rd_byte; sda_oe <= ~rd_byte[7]; cnt <= 4'd1;
              end else st <= IDLE;
            default: ;
          endcase
      end
      if (osc_stop) osf_q <= 1'b1;
    end
endmodule

// File: rtl/rtc_bus_regs_chk.sv
module rtc_bus_regs_chk #(
  parameter int TIME_BYTES = 7
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_fail,
  input logic       wr_en,
  input logic [3:0] wr_addr,
  input logic [7:0] wr_data,
  input logic [7:0] ctrl_q,
  input logic [7:0] chg_q,
  input logic       osf_q
);
  localparam logic [3:0] CTRL_A = 4'(TIME_BYTES);
  localparam logic [3:0] CHG_A  = CTRL_A + 4'd1;
  localparam logic [3:0] FLAG_A = CTRL_A + 4'd2;

  a_r9_no_commit_in_power_fail: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pwr_fail) |-> !wr_en);

  a_r3_write_addr_in_map: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_addr <= FLAG_A);

  a_r7_flag_clears_by_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osf_q) |-> (wr_en && wr_addr == FLAG_A && !wr_data[7]));

  a_r11_ctrl_moves_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q) |-> (wr_en && wr_addr == CTRL_A && wr_data == ctrl_q));

  a_r8_chg_moves_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chg_q) |-> (wr_en && wr_addr == CHG_A && wr_data == chg_q));
endmodule

bind rtc_bus_regs rtc_bus_regs_chk #(.TIME_BYTES(TIME_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .ctrl_q(ctrl_q), .chg_q(chg_q), .osf_q(osf_q));

// File: tb/rtc_bus_regs_tb.sv
module rtc_bus_regs_tb;
  localparam int Q = 8;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        scl_m = 1'b1, sda_m = 1'b1, pwr_fail = 1'b0, osc_stop = 1'b0;
  logic [55:0] live = '0;
  logic        sda_oe, wr_en, chg_en, osf_q;
  logic [3:0]  wr_addr;
  logic [7:0]  wr_data, ctrl_q, chg_q;
  wire         sda_line = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  rtc_bus_regs u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .pwr_fail(pwr_fail), .osc_stop(osc_stop), .live_time(live), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .ctrl_q(ctrl_q), .chg_q(chg_q),
    .chg_en(chg_en), .osf_q(osf_q));

  int checks = 0, fails = 0, wr_cnt = 0;
  logic [3:0] ha [3];
  logic [7:0] hd [3];

  always @(posedge clk)
    if (rst_n && wr_en) begin
      wr_cnt = wr_cnt + 1;
      ha[2] = ha[1]; ha[1] = ha[0]; ha[0] = wr_addr;
      hd[2] = hd[1]; hd[1] = hd[0]; hd[0] = wr_data;
    end

  // ptr, write data, expected read, expected chg_en
  localparam logic [31:0] VEC [11] = '{
    32'h07_5A_5A_00, 32'h08_A5_A5_01, 32'h08_A6_A6_01, 32'h08_AB_AB_01,
    32'h08_AC_AC_00, 32'h08_A0_A0_00, 32'h08_A9_A9_01, 32'h08_5A_5A_00,
    32'h09_FF_80_00, 32'h09_7F_00_00, 32'h09_FF_00_00};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic qw(input int n = Q);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; qw(); scl_m = 1'b1; qw(); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(Q/2);
    ack = ~sda_line;
    qw(Q/2); scl_m = 1'b0;
  endtask

  task automatic recv_byte(input logic last, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      qw(); scl_m = 1'b1; qw(Q/2);
      b = {b[6:0], sda_line};
      qw(Q/2); scl_m = 1'b0;
    end
    sda_m = last; qw(); scl_m = 1'b1; qw(); scl_m = 1'b0;
  endtask

  task automatic read_at(input logic [7:0] p, output logic [7:0] d);
    logic a;
    bus_start(); send_byte(8'hD0, a); send_byte(p, a);
    bus_start(); send_byte(8'hD1, a); recv_byte(1'b1, d); bus_stop();
  endtask

  task automatic write3(input logic [7:0] p, input int n, input logic [7:0] d0,
                        input logic [7:0] d1, input logic [7:0] d2);
    logic a;
    bus_start(); send_byte(8'hD0, a); chk("R1 address ack", a, 1);
    send_byte(p, a);
    if (n > 0) send_byte(d0, a);
    if (n > 1) send_byte(d1, a);
    if (n > 2) send_byte(d2, a);
    bus_stop();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic a;
    int c0;
    qw(4); rst_n = 1'b1; qw(4);

    chk("R11 ctrl reset", ctrl_q, 8'h80);
    chk("R8 chg reset", chg_q, 8'h00);
    chk("R8 chg_en reset", chg_en, 0);
    chk("R7 flag reset", osf_q, 1);
    chk("R6 sda released at reset", sda_oe, 0);

    for (int v = 0; v < 11; v++) begin
      write3(VEC[v][31:24], 1, VEC[v][23:16], 8'h00, 8'h00);
      chk("R2 write strobe addr", ha[0], VEC[v][27:24]);
      read_at(VEC[v][31:24], d);
      chk(VEC[v][31:24] == 8'h07 ? "R11 ctrl readback" :
          VEC[v][31:24] == 8'h08 ? "R8 chg readback" : "R7 flag readback", d, VEC[v][15:8]);
      chk("R8 chg_en decode", chg_en, VEC[v][0]);
    end

    // R4 snapshot, R3 wrap on read, R6 continuous read
    live = 56'h77665544332211;
    write3(8'h00, 0, 8'h00, 8'h00, 8'h00);
    live = 56'h27262524232221;
    bus_start(); send_byte(8'hD1, a); chk("R6 read address ack", a, 1);
    recv_byte(1'b0, d); chk("R4 snapshot at START", d, 8'h21);
    live = 56'h37363534333231;
    for (int k = 1; k < 7; k++) begin
      recv_byte(1'b0, d); chk("R4 snapshot held", d, 8'h20 + 8'(k) + 8'h1);
    end
    recv_byte(1'b0, d); chk("R11 ctrl in burst", d, 8'h5A);
    recv_byte(1'b1, d); chk("R3 R4 wrap to 00 refreshes", d, 8'h31);
    qw();
    chk("R6 release after NACK", sda_oe, 0);
    qw(2*Q);
    chk("R6 stays released", sda_oe, 0);
    bus_stop();
    bus_start(); send_byte(8'hD1, a); recv_byte(1'b1, d); bus_stop();
    chk("R6 read from stored pointer", d, 8'h32);

    // R3 write wraps
    write3(8'h06, 3, 8'hC6, 8'hC7, 8'hC0);
    chk("R3 wrap seq a", {ha[2], ha[1], ha[0]}, 12'h670);
    chk("R2 data seq", {hd[2], hd[1], hd[0]}, 24'hC6C7C0);
    chk("R11 ctrl written", ctrl_q, 8'hC7);
    write3(8'h08, 3, 8'hA5, 8'h80, 8'h12);
    chk("R3 wrap seq b", {ha[2], ha[1], ha[0]}, 12'h890);
    chk("R8 chg_en on", chg_en, 1);
    chk("R7 write 1 no set", osf_q, 0);

    @(negedge clk) osc_stop = 1'b1; @(negedge clk) osc_stop = 1'b0;
    chk("R7 osc_stop sets", osf_q, 1);
    read_at(8'h09, d); chk("R7 flag read", d, 8'h80);

    // R1 wrong address
    c0 = wr_cnt;
    bus_start(); send_byte(8'hD2, a); chk("R1 wrong addr nack", a, 0);
    send_byte(8'h07, a); send_byte(8'h11, a); bus_stop();
    bus_start(); send_byte(8'h50, a); chk("R1 other addr nack", a, 0); bus_stop();
    chk("R1 no write", wr_cnt, c0);
    chk("R1 ctrl kept", ctrl_q, 8'hC7);

    // R9 power fail
    pwr_fail = 1'b1;
    bus_start(); send_byte(8'hD0, a); chk("R9 nack in power fail", a, 0);
    send_byte(8'h07, a); send_byte(8'h00, a); bus_stop();
    pwr_fail = 1'b0;
    chk("R9 no write", wr_cnt, c0);
    chk("R9 ctrl kept", ctrl_q, 8'hC7);

    // R10 repeated START aborts partial byte
    bus_start(); send_byte(8'hD0, a); send_byte(8'h07, a);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_start(); send_byte(8'hD1, a); recv_byte(1'b1, d); bus_stop();
    chk("R10 pointer kept", d, 8'hC7);
    chk("R10 no write", wr_cnt, c0);
    chk("R10 ctrl kept", ctrl_q, 8'hC7);

    // R5 commit at ACK
    bus_start(); send_byte(8'hD0, a); send_byte(8'h07, a);
    for (int i = 7; i >= 1; i--) send_bit(i[0]);
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw();
    chk("R5 not before ack", wr_cnt, c0);
    scl_m = 1'b0; qw();
    chk("R5 committed at ack", wr_cnt, c0 + 1);
    chk("R5 ack driven", sda_oe, 1);
    sda_m = 1'b1; scl_m = 1'b1; qw(); scl_m = 1'b0;
    bus_stop();
    chk("R5 ctrl value", ctrl_q, 8'hAA);

    finish_run();
  end
endmodule